// File: doc/BRIEF.md
# Gated Continuous-Scan Queue Sequencer

This block steps through a table of conversion command slots for as long as an external gate input is held open. It issues one request at a time to an analog-to-digital converter over a start/done handshake. It begins at slot 0 and walks upward to a programmable last slot. On reaching the last slot it wraps back to slot 0 and continues until the gate closes or software clears the mode enable. The converter itself, the command contents and the result storage sit outside this block.

The block keeps three sticky status flags. The completion flag records that the queue has run to its end once during the current gate window. The overrun flag records that the queue has run to its end again within the same window. The incomplete flag records that the gate shut the queue down part way through. An output pointer names the slot of the most recent conversion that finished. A small write port sets the queue length and the enable, and clears the flags.

Top module: `gscan_top`

## Requirements
- R1: The gate input passes through two synchronizing flops and only the synchronized level is used. When the block is idle and enabled, and the gate input goes high ahead of clock edge k, `convStart` is low after edges k and k+1 and high after edge k+2.
- R2: `convStart` is a one-cycle pulse. No further pulse comes until `convDone` has answered the previous one. If the gate is still open, the next pulse follows in the cycle after `convDone`.
- R3: Requests carry slot indices 0, 1, 2 and so on up to the last slot, then wrap to 0. The last slot is set by writing (length − 1) to address 1, bits [IDX_W-1:0], which allows a length from 1 to MAX_LEN.
- R4: When the last slot finishes for the first time since the gate opened, status bit 0 (`cmplFlag`) is set.
- R5: When the last slot finishes a second or later time within the same gate window, status bit 1 (`ovrFlag`) is set.
- R6: After the gate closes, the conversion in flight still finishes and no new request is issued. Status bit 2 (`pauseFlag`) is then set, unless the conversion that finished was the last slot.
- R7: `lastIdx` holds the slot index of the most recent `convDone`. It keeps that value through a stop, a disable and idle time.
- R8: Whenever the gate reopens after a stop, the first request is for slot 0.
- R9: Writing 0 to address 0, bit 0 (the mode enable) lets the conversion in flight finish and then stops the block without setting `pauseFlag`. Writing 1 to that bit enables the block. The enable is 1 after reset.
- R10: Flags stay set until a write to address 2 with a 1 in that flag's bit (bit 0 = completion, bit 1 = overrun, bit 2 = incomplete). A 0 bit in that write leaves its flag unchanged, and a set event in the same cycle wins over the clear.
- R11: After reset, every flag is 0, `lastIdx` is 0, no request is pending and the length is MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gateIn | input | 1 | Asynchronous gate level; high means open |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 enable, 1 length−1, 2 flag clear |
| wrData | input | IDX_W | Write data |
| convStart | output | 1 | One-cycle conversion request |
| convIdx | output | IDX_W | Slot index of the request |
| convDone | input | 1 | One-cycle completion from the converter |
| cmplFlag | output | 1 | Sticky completion flag |
| ovrFlag | output | 1 | Sticky overrun flag |
| pauseFlag | output | 1 | Sticky incomplete-queue flag |
| lastIdx | output | IDX_W | Slot of the last finished conversion |

## Verification
A wrong slot counter appears on `convIdx` at the very next request, so the bench compares every pulse with an index it keeps for itself, modulo the length. A lost or extra wrap-tracking bit swaps which of the completion and overrun flags rises, and the bench sees this one conversion after the wrap. A control state that fails to settle shows up within a few cycles of gate closure, either as an extra `convStart` or as a wrong incomplete flag. An off-by-one in the synchronizer shows up as a start pulse one cycle away from where R1 places it.

// File: rtl/gscan_pkg.sv
package gscan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;   // hold slot counter and wrap tracking at start
    logic advance;   // a conversion has just finished
    logic setPause;  // gate closed mid-queue
  } dpStrobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LEN  = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;
endpackage

// File: rtl/gscan_sync.sv
module gscan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/gscan_ctrl.sv
module gscan_ctrl
  import gscan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gateSync,
  input  logic       enable,
  input  logic       atEnd,
  input  logic       convDone,
  output logic       convStart,
  output dpStrobe_t  strb
);
  scanState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        strb.restart = 1'b1;
        if (enable && gateSync) nextState = ST_ISSUE;
      end
      ST_ISSUE: nextState = ST_WAIT;
      ST_WAIT: begin
        if (convDone) begin
          strb.advance = 1'b1;
          if (enable && gateSync) nextState = ST_ISSUE;
          else begin
            nextState = ST_IDLE;
            strb.setPause = enable && !atEnd;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign convStart = (state == ST_ISSUE);

  // R2: a request is never followed directly by another
  p_single_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R6 / R9: a request only follows an open gate while enabled
  p_start_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(gateSync && enable));
endmodule

// File: rtl/gscan_dp.sv
module gscan_dp
  import gscan_pkg::*;
#(
  parameter int MAX_LEN = 64,
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [IDX_W-1:0] wrData,
  input  dpStrobe_t        strb,
  output logic             enable,
  output logic             atEnd,
  output logic [IDX_W-1:0] slotIdx,
  output logic             cmplFlag,
  output logic             ovrFlag,
  output logic             pauseFlag,
  output logic [IDX_W-1:0] lastIdx
);
  localparam logic [IDX_W-1:0] LEN_M1_RST = IDX_W'(MAX_LEN - 1);

  logic [IDX_W-1:0] lenM1;
  logic             wrapSeen;
  logic             wrCtrl, wrLen, wrClr;
  logic             setCmpl, setOvr;

  assign wrCtrl  = wrEn && (wrAddr == ADDR_CTRL);
  assign wrLen   = wrEn && (wrAddr == ADDR_LEN);
  assign wrClr   = wrEn && (wrAddr == ADDR_CLR);
  assign atEnd   = (slotIdx >= lenM1);
  assign setCmpl = strb.advance && atEnd && !wrapSeen;
  assign setOvr  = strb.advance && atEnd && wrapSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b1;
      lenM1  <= LEN_M1_RST;
    end else begin
      if (wrCtrl) enable <= wrData[0];
      if (wrLen)  lenM1  <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotIdx  <= '0;
      wrapSeen <= 1'b0;
      lastIdx  <= '0;
    end else if (strb.restart) begin
      slotIdx  <= '0;
      wrapSeen <= 1'b0;
    end else if (strb.advance) begin
      lastIdx <= slotIdx;
      if (atEnd) begin
        slotIdx  <= '0;
        wrapSeen <= 1'b1;
      end else begin
        slotIdx <= slotIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmplFlag  <= 1'b0;
      ovrFlag   <= 1'b0;
      pauseFlag <= 1'b0;
    end else begin
      cmplFlag  <= (cmplFlag  && !(wrClr && wrData[0])) || setCmpl;
      ovrFlag   <= (ovrFlag   && !(wrClr && wrData[1])) || setOvr;
      pauseFlag <= (pauseFlag && !(wrClr && wrData[2])) || strb.setPause;
    end
  end

  // R3: finishing the last slot sends the next request to slot 0
  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && atEnd) |=> (slotIdx == '0));

  // R5: a repeated wrap in one window always leaves the overrun flag set
  p_ovr_on_rewrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && atEnd && wrapSeen) |=> ovrFlag);

  // R10: completion flag survives anything but its own clear bit
  p_cmpl_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmplFlag && !(wrEn && wrAddr == ADDR_CLR && wrData[0])) |=> cmplFlag);

  // R7: the pointer moves only when a conversion finishes
  p_last_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(lastIdx));
endmodule

// File: rtl/gscan_top.sv
module gscan_top
  import gscan_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateIn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [IDX_W-1:0] wrData,
  output logic             convStart,
  output logic [IDX_W-1:0] convIdx,
  input  logic             convDone,
  output logic             cmplFlag,
  output logic             ovrFlag,
  output logic             pauseFlag,
  output logic [IDX_W-1:0] lastIdx
);
  logic      gateSync, enable, atEnd;
  dpStrobe_t strb;

  gscan_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(gateIn), .syncOut(gateSync)
  );

  gscan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .gateSync(gateSync), .enable(enable),
    .atEnd(atEnd), .convDone(convDone), .convStart(convStart), .strb(strb)
  );

  gscan_dp #(.MAX_LEN(MAX_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .enable(enable), .atEnd(atEnd), .slotIdx(convIdx),
    .cmplFlag(cmplFlag), .ovrFlag(ovrFlag), .pauseFlag(pauseFlag),
    .lastIdx(lastIdx)
  );
endmodule

// File: tb/sim_gscan_top.sv
module sim_gscan_top;
  localparam int MAX_LEN = 64;
  localparam int IDX_W   = $clog2(MAX_LEN);
  localparam int NVEC    = 6;
  // vector table: queue length, gate-open cycles, converter delay
  localparam int VLEN  [NVEC] = '{4, 8, 1, 64, 3, 5};
  localparam int VOPEN [NVEC] = '{40, 12, 20, 30, 9, 200};
  localparam int VDLY  [NVEC] = '{1, 3, 2, 1, 2, 7};

  logic clk = 1'b0, rstN = 1'b0, gateIn = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [IDX_W-1:0] wrData = '0;
  logic convStart, convDone, cmplFlag, ovrFlag, pauseFlag;
  logic [IDX_W-1:0] convIdx, lastIdx;

  int checks = 0, fails = 0;
  int curLen = MAX_LEN, curDly = 1, dlyCnt = 0;
  int expIdx = 0, startCnt = 0, doneCnt = 0;
  bit outstanding = 0, done_flag = 0;

  always #5 clk = ~clk;

  gscan_top #(.MAX_LEN(MAX_LEN)) u0 (
    .clk(clk), .rstN(rstN), .gateIn(gateIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .convStart(convStart), .convIdx(convIdx),
    .convDone(convDone), .cmplFlag(cmplFlag), .ovrFlag(ovrFlag),
    .pauseFlag(pauseFlag), .lastIdx(lastIdx)
  );

  // converter model: done arrives curDly cycles after the request edge
  always @(posedge clk) begin
    if (convStart)       dlyCnt <= curDly;
    else if (dlyCnt > 0) dlyCnt <= dlyCnt - 1;
  end
  assign convDone = (dlyCnt == 1);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // request monitor: R2 handshake, R3/R8 slot order
  always @(negedge clk) begin
    if (rstN && convStart) begin
      check(!outstanding, "R2 request while busy", 1, 0);
      check(convIdx == IDX_W'(expIdx % curLen), "R3/R8 slot index",
            int'(convIdx), expIdx % curLen);
      outstanding = 1;
      expIdx++;
      startCnt++;
    end
    if (rstN && convDone) begin
      outstanding = 0;
      doneCnt++;
    end
  end

  task automatic regWrite(input logic [1:0] a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = IDX_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finishUp();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishUp();
  end

  initial begin
    int n0, n, s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!cmplFlag && !ovrFlag && !pauseFlag, "R11 flags after reset",
          {cmplFlag, ovrFlag, pauseFlag}, 0);
    check(lastIdx == '0, "R11 pointer after reset", int'(lastIdx), 0);
    check(!convStart, "R11 no request after reset", int'(convStart), 0);

    // R1 synchronizer latency
    regWrite(2'd1, 3); curLen = 4; curDly = 20; expIdx = 0;
    @(negedge clk); gateIn = 1'b1;
    @(negedge clk); check(!convStart, "R1 edge k", int'(convStart), 0);
    @(negedge clk); check(!convStart, "R1 edge k+1", int'(convStart), 0);
    @(negedge clk); check(convStart, "R1 edge k+2", int'(convStart), 1);
    gateIn = 1'b0;
    repeat (30) @(negedge clk);

    // table-driven windows: R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      regWrite(2'd2, 7);
      regWrite(2'd1, VLEN[v] - 1);
      curLen = VLEN[v]; curDly = VDLY[v]; expIdx = 0;
      n0 = doneCnt;
      @(negedge clk); gateIn = 1'b1;
      repeat (VOPEN[v]) @(negedge clk);
      gateIn = 1'b0;
      repeat (VDLY[v] + 10) @(negedge clk);
      n = doneCnt - n0;
      s0 = startCnt;
      repeat (10) @(negedge clk);
      check(startCnt == s0, "R6 no request after gate close", startCnt - s0, 0);
      check(!outstanding, "R6 in-flight finished", int'(outstanding), 0);
      check(n > 0, "R3 window converted", n, 1);
      check(cmplFlag == (n >= curLen), "R4 completion flag", int'(cmplFlag), int'(n >= curLen));
      check(ovrFlag == (n >= 2 * curLen), "R5 overrun flag", int'(ovrFlag), int'(n >= 2 * curLen));
      check(pauseFlag == (n % curLen != 0), "R6 incomplete flag", int'(pauseFlag), int'(n % curLen != 0));
      check(lastIdx == IDX_W'((n - 1) % curLen), "R7 last pointer",
            int'(lastIdx), (n - 1) % curLen);
    end

    // R9 disable while gate stays open
    regWrite(2'd2, 7);
    regWrite(2'd1, 7); curLen = 8; curDly = 3; expIdx = 0;
    n0 = doneCnt;
    @(negedge clk); gateIn = 1'b1;
    repeat (14) @(negedge clk);
    regWrite(2'd0, 0);
    repeat (10) @(negedge clk);
    n = doneCnt - n0;
    s0 = startCnt;
    repeat (10) @(negedge clk);
    check(startCnt == s0, "R9 stopped after disable", startCnt - s0, 0);
    check(!pauseFlag, "R9 no incomplete flag on disable", int'(pauseFlag), 0);
    check(lastIdx == IDX_W'((n - 1) % 8), "R7 pointer kept after disable", int'(lastIdx), (n - 1) % 8);
    gateIn = 1'b0;
    repeat (5) @(negedge clk);
    check(lastIdx == IDX_W'((n - 1) % 8), "R7 pointer kept while idle", int'(lastIdx), (n - 1) % 8);
    regWrite(2'd0, 1);

    // R10 clear semantics: build all three flags first
    regWrite(2'd1, 1); curLen = 2; curDly = 2; expIdx = 0;
    @(negedge clk); gateIn = 1'b1;
    repeat (14) @(negedge clk);
    gateIn = 1'b0;
    repeat (12) @(negedge clk);
    check(cmplFlag && ovrFlag, "R10 flags set before clear", {cmplFlag, ovrFlag}, 3);
    regWrite(2'd2, 0);
    check(cmplFlag && ovrFlag, "R10 zero write keeps flags", {cmplFlag, ovrFlag}, 3);
    regWrite(2'd2, 1);
    check(!cmplFlag && ovrFlag, "R10 clear completion only", {cmplFlag, ovrFlag}, 1);
    regWrite(2'd2, 2);
    check(!ovrFlag, "R10 clear overrun", int'(ovrFlag), 0);

    // R8 reopen restarts at slot 0 after a mid-queue stop
    regWrite(2'd1, 9); curLen = 10; curDly = 1; expIdx = 0;
    @(negedge clk); gateIn = 1'b1;
    repeat (8) @(negedge clk);
    gateIn = 1'b0;
    repeat (12) @(negedge clk);
    expIdx = 0; s0 = startCnt;
    gateIn = 1'b1;
    repeat (4) @(negedge clk);
    check(startCnt == s0 + 1, "R8 reopen issued request", startCnt - s0, 1);
    gateIn = 1'b0;
    repeat (12) @(negedge clk);

    finishUp();
  end
endmodule